// File: doc/BRIEF.md
# Int8 dot-product MAC array

This block is the multiply-accumulate core of a convolution engine. On every accepted input beat it receives one activation vector, which all MAC units share, and one weight vector per unit, where each unit serves a different output channel. Each unit multiplies its weight vector lane by lane against the shared activations and adds the sum of the products to its own 32-bit accumulator. A run of beats is framed by a first flag, which restarts the accumulators, and a last flag, which ends the run. When a run ends, each accumulator is scaled down to a signed 8-bit value and all units present their results together in a single output beat.

The native operands are signed 8-bit values. A wide mode takes signed 16-bit operands. It builds each 16x16 product from four byte-wide partial products over four cycles, using the same multipliers, so the array runs at a quarter of its byte throughput in that mode. A lane whose two operand bytes include a zero keeps its multiplier inputs at zero and adds nothing. The block stalls its input by dropping `in_ready` while a wide beat is still in progress or an output beat is showing. The output beat has no backpressure.

Top module: `dotmac_array`

## Requirements
- R1: In byte mode (`in_wide`=0), an accepted beat adds to the accumulator of unit u the sum over lanes l of signed `act` bits [16l+7:16l] times signed `wgt` bits [(u*LANES+l)*16+7:(u*LANES+l)*16]. The upper byte of every 16-bit operand field has no effect on the result.
- R2: A beat accepted with `in_first`=1 replaces each accumulator with that beat's own contribution and drops the earlier sum. Beats without the flag add to the running sum, and byte and wide beats may be mixed within one run.
- R3: In wide mode (`in_wide`=1), an accepted beat adds the sum of full signed 16-bit products over each lane's 16-bit fields. `in_ready` then stays low for the three cycles after the accepting edge, which gives at most one wide beat every four cycles.
- R4: A lane whose activation byte or weight byte is zero contributes nothing. With all activations zero, or all weights zero, every output equals the saturated value of `q_zp`.
- R5: Each accumulator is 32 bits wide and wraps modulo 2^32 on overflow.
- R6: Each output is computed as follows. Multiply the signed accumulator by the signed 16-bit `q_mult`. If `q_shift` (0..31) is nonzero, add 2^(`q_shift`-1) and shift arithmetically right by `q_shift`. Finally, add the signed 8-bit `q_zp`. Unit u's result is placed on `out_data` bits [8u+7:8u].
- R7: A requantized value above 127 is output as 127, and one below -128 is output as -128.
- R8: `out_valid` is high for exactly one cycle per run. This is the cycle after the edge that accepted a byte-mode last beat, or four cycles after the edge that accepted a wide-mode last beat. `in_ready` is low while `out_valid` is high.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can accept a beat this cycle |
| in_first | input | 1 | Beat opens a new run |
| in_last | input | 1 | Beat closes the run |
| in_wide | input | 1 | Beat carries 16-bit operands |
| act | input | LANES*16 | Shared activation vector, 16 bits per lane |
| wgt | input | UNITS*LANES*16 | Weight vectors, 16 bits per lane per unit |
| q_mult | input | 16 | Signed requantization multiplier |
| q_shift | input | 5 | Rounding right shift amount |
| q_zp | input | 8 | Signed output zero point |
| out_valid | output | 1 | Output beat strobe |
| out_data | output | UNITS*8 | Requantized signed 8-bit results, one per unit |

## Verification
A corrupted accumulator, a misplaced partial-product shift or a wrong byte signedness does not show at the ports until the end of the run. It then shows as a wrong byte on one unit's slot of `out_data`, because the outputs are the only view of the sums. A fault in the wide-mode phase counter or the output-pending flag shows sooner. It appears at `in_ready` or `out_valid` within four cycles of the accepting edge, as a stall that is too long or too short, or as a strobe that is missing or lasts two cycles. Zero gating and accumulator wrap are observable only through result values. The sweeps therefore use high zero densities and extreme operand values so that such faults change the requantized bytes.

// File: rtl/dotmac_array.sv
module dotmac_array #(
  parameter int UNITS = 8,
  parameter int LANES = 16,
  parameter int ACCW  = 32,
  parameter int OUTW  = 8,
  parameter int MULW  = 16,
  parameter int SHW   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_first,
  input  logic                      in_last,
  input  logic                      in_wide,
  input  logic [LANES*16-1:0]       act,
  input  logic [UNITS*LANES*16-1:0] wgt,
  input  logic [MULW-1:0]           q_mult,
  input  logic [SHW-1:0]            q_shift,
  input  logic [OUTW-1:0]           q_zp,
  output logic                      out_valid,
  output logic [UNITS*OUTW-1:0]     out_data
);
  localparam int OPW = 16;
  localparam int PRW = ACCW + MULW + 1;
  localparam logic signed [PRW-1:0] QMAX = PRW'((1 << (OUTW - 1)) - 1);
  localparam logic signed [PRW-1:0] QMIN = -QMAX - PRW'(1);

  logic                      busy, pend, wlast;
  logic [1:0]                ph;
  logic [LANES*OPW-1:0]      act_q;
  logic [UNITS*LANES*OPW-1:0] wgt_q;

  wire take = in_valid && in_ready;
  wire step = take || busy;
  wire [1:0] cph = busy ? ph : 2'd0;
  wire wmode = busy || in_wide;
  wire a_sx = wmode ? cph[1] : 1'b1;
  wire w_sx = wmode ? cph[0] : 1'b1;
  wire [4:0] shamt = {cph[1] & cph[0], cph[1] ^ cph[0], 3'b000};
  wire [LANES*OPW-1:0]       act_s = busy ? act_q : act;
  wire [UNITS*LANES*OPW-1:0] wgt_s = busy ? wgt_q : wgt;

  assign in_ready  = !busy && !pend;
  assign out_valid = pend;

  function automatic logic signed [17:0] lane_prod(input logic [7:0] ab, input logic [7:0] wb,
                                                   input logic asx, input logic wsx);
    logic signed [8:0] ae, we;
    logic gate;
    gate = (ab != 8'd0) && (wb != 8'd0);
    ae = gate ? signed'({asx & ab[7], ab}) : 9'sd0;
    we = gate ? signed'({wsx & wb[7], wb}) : 9'sd0;
    return ae * we;
  endfunction

  function automatic logic [OUTW-1:0] requant(input logic [ACCW-1:0] a, input logic [MULW-1:0] m,
                                              input logic [SHW-1:0] sh, input logic [OUTW-1:0] zp);
    logic signed [PRW-1:0] p;
    p = PRW'(signed'(a)) * PRW'(signed'(m));
    if (sh != '0) p = p + (PRW'(1) << (sh - SHW'(1)));
    p = p >>> sh;
    p = p + PRW'(signed'(zp));
    if (p > QMAX) return QMAX[OUTW-1:0];
    if (p < QMIN) return QMIN[OUTW-1:0];
    return p[OUTW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (take) begin
      act_q <= act;
      wgt_q <= wgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pend  <= 1'b0;
      wlast <= 1'b0;
      ph    <= 2'd0;
    end else begin
      pend <= 1'b0;
      if (take) begin
        wlast <= in_last;
        if (in_wide) begin
          busy <= 1'b1;
          ph   <= 2'd1;
        end else begin
          pend <= in_last;
        end
      end else if (busy) begin
        ph <= ph + 2'd1;
        if (ph == 2'd3) begin
          busy <= 1'b0;
          pend <= wlast;
        end
      end
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [ACCW-1:0] sum, acc;
    always_comb begin
      sum = '0;
      for (int l = 0; l < LANES; l++)
        sum = sum + (ACCW'(lane_prod(
          cph[1] ? act_s[l*OPW+8 +: 8] : act_s[l*OPW +: 8],
          cph[0] ? wgt_s[(u*LANES+l)*OPW+8 +: 8] : wgt_s[(u*LANES+l)*OPW +: 8],
          a_sx, w_sx)) << shamt);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc <= '0;
      else if (take && in_first) acc <= sum;
      else if (step)             acc <= acc + sum;
    end
    assign out_data[u*OUTW +: OUTW] = requant(acc, q_mult, q_shift, q_zp);
  end
endmodule

// File: rtl/dotmac_array_chk.sv
module dotmac_array_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_wide,
  input logic in_last,
  input logic out_valid
);
  wire take_n = in_valid && in_ready && !in_wide;
  wire take_w = in_valid && in_ready && in_wide;

  p_one_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_out_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_narrow_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_n && in_last) |=> out_valid);
  p_wide_hold1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> !in_ready);
  p_wide_hold3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_w, 3) |-> !in_ready);
  p_wide_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_w && in_last, 4) |-> out_valid);
  p_wide_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_w && !in_last, 4) |-> in_ready);
endmodule

bind dotmac_array dotmac_array_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_wide(in_wide), .in_last(in_last), .out_valid(out_valid)
);

// File: tb/dotmac_array_tb.sv
module dotmac_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int U = 8;
  localparam int L = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_wide = 1'b0;
  logic [L*16-1:0]   act = '0;
  logic [U*L*16-1:0] wgt = '0;
  logic [15:0] q_mult = 16'd1;
  logic [4:0]  q_shift = 5'd0;
  logic [7:0]  q_zp = 8'd0;
  wire in_ready, out_valid;
  wire [U*8-1:0] out_data;

  int nvec = 0, nbad = 0;
  int model [U];

  dotmac_array u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_wide(in_wide),
    .act(act), .wgt(wgt), .q_mult(q_mult), .q_shift(q_shift), .q_zp(q_zp),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(string tag, int got, int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int expq(int a);
    longint p;
    p = longint'(a) * longint'($signed(q_mult));
    if (q_shift != 0) p = (p + (64'sd1 <<< (q_shift - 1))) >>> q_shift;
    p = p + longint'($signed(q_zp));
    if (p > 127) p = 127;
    if (p < -128) p = -128;
    return int'(p);
  endfunction

  function automatic logic [15:0] pick(int zpct);
    int r;
    r = $urandom % 100;
    if (r < zpct) return 16'h0000;
    if (r < zpct + (100 - zpct) / 5) return {8'($urandom), 8'h00};
    return 16'($urandom);
  endfunction

  task automatic fill(int zpa, int zpw);
    for (int l = 0; l < L; l++) act[l*16 +: 16] = pick(zpa);
    for (int k = 0; k < U*L; k++) wgt[k*16 +: 16] = pick(zpw);
  endtask

  task automatic send(bit first, bit last, bit wide, string tag);
    int n;
    logic [15:0] a, w;
    for (int u = 0; u < U; u++) begin
      if (first) model[u] = 0;
      for (int l = 0; l < L; l++) begin
        a = act[l*16 +: 16];
        w = wgt[(u*L+l)*16 +: 16];
        if (wide) model[u] += int'($signed(a)) * int'($signed(w));
        else      model[u] += int'($signed(a[7:0])) * int'($signed(w[7:0]));
      end
    end
    in_first = first; in_last = last; in_wide = wide; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (last) begin
      n = 1;
      while (!out_valid && n < 8) begin
        @(negedge clk);
        n++;
      end
      chk("R8 output latency", n, wide ? 4 : 1);
      chk("R8 ready low during output", int'(in_ready), 0);
      for (int u = 0; u < U; u++)
        chk(tag, int'($signed(out_data[u*8 +: 8])), expq(model[u]));
      @(negedge clk);
      chk("R8 single output cycle", int'(out_valid), 0);
    end
  endtask

  task automatic rand_q();
    q_mult  = 16'($urandom);
    q_shift = 5'($urandom);
    q_zp    = 8'($urandom);
  endtask

  initial begin
    int nb;
    bit wd;
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", int'(out_valid), 0);
    chk("R9 in_ready after reset", int'(in_ready), 1);

    // R1 byte runs, R3 wide runs, R2 mixed multi-beat runs with first clearing
    for (int r = 0; r < 90; r++) begin
      rand_q();
      if (r % 2 == 0) q_shift = 5'(8 + $urandom % 16);
      nb = 1 + $urandom % 4;
      for (int b = 0; b < nb; b++) begin
        fill((r % 4) * 25, ((r / 4) % 4) * 25);
        wd = (r % 3 == 1) || (r % 3 == 2 && ($urandom % 2 == 1));
        send(b == 0, b == nb - 1, wd, (r % 3 == 0) ? "R1 byte run" :
                                      (r % 3 == 1) ? "R3 wide run" : "R2 mixed run");
      end
    end

    // R4 zero operands on one side
    for (int r = 0; r < 8; r++) begin
      rand_q();
      if (r % 2 == 0) fill(100, 0); else fill(0, 100);
      send(1'b1, 1'b0, r[1], "R4 zero side");
      send(1'b0, 1'b1, !r[1], "R4 zero side");
    end

    // R6 shift sweep with small multipliers
    for (int s = 0; s < 32; s++) begin
      q_shift = 5'(s);
      q_mult  = 16'($signed(($urandom % 601)) - 300);
      q_zp    = 8'($urandom);
      fill(10, 10);
      send(1'b1, 1'b1, s[0], "R6 shift sweep");
    end

    // R7 saturation both ways
    q_mult = 16'd1; q_shift = 5'd0; q_zp = 8'd0;
    for (int l = 0; l < L; l++) act[l*16 +: 16] = 16'h0080;
    for (int k = 0; k < U*L; k++) wgt[k*16 +: 16] = 16'h0080;
    send(1'b1, 1'b1, 1'b0, "R7 high saturation");
    for (int k = 0; k < U*L; k++) wgt[k*16 +: 16] = 16'h007f;
    send(1'b1, 1'b1, 1'b0, "R7 low saturation");

    // R5 accumulator wrap with extreme wide operands
    for (int s = 16; s < 32; s += 5) begin
      q_mult = 16'd1; q_shift = 5'(s); q_zp = 8'd0;
      for (int l = 0; l < L; l++) act[l*16 +: 16] = 16'h8000;
      for (int k = 0; k < U*L; k++) wgt[k*16 +: 16] = (k % 3 == 0) ? 16'h7fff : 16'h8001;
      send(1'b1, 1'b0, 1'b1, "R5 wrap");
      send(1'b0, 1'b0, 1'b1, "R5 wrap");
      send(1'b0, 1'b1, 1'b1, "R5 wrap");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule